// File: doc/BRIEF.md
# Microcontroller Special Register Unit

This block holds three pieces of state for a small 8-bit accumulator machine. The first is the processor status byte. The second is the 8-bit stack pointer. The third is the 16-bit data pointer. Software reads and writes them one byte at a time over a special-register bus. The read path is combinational, so read data is valid in the same cycle as the address.

Side-band strobes from the rest of the core also change the state. Push and pop strobes move the stack pointer, and the unit shows the stack address to use in that same cycle. ALU strobes update the carry, auxiliary carry and overflow bits. A 16-bit load port writes the whole data pointer in one cycle.

The parity bit is never stored. It is always computed from the live accumulator. Two status bits select one of four 8-byte working-register banks, and the unit drives that bank's base address. The core uses the full data pointer for indirect memory access.

Top module: `mcu_sreg_unit`

## Requirements
- R1: Reset behaviour:
  - While `rst_n` is low, the stack pointer is 0x07 and the data pointer is 0x0000.
  - Every stored status bit is 0, so `bank_base` is 0x00.
- R2: Push:
  - In a cycle with `push` high, `stk_addr` equals the stack pointer plus one, modulo 256.
  - At the next edge the stack pointer takes that value.
  - The first push after reset therefore uses address 0x08, and 0xFF wraps to 0x00.
- R3: Pop:
  - In a cycle with `pop` high and `push` low, `stk_addr` equals the current stack pointer.
  - At the next edge the stack pointer decrements modulo 256, so 0x00 becomes 0xFF.
  - When both strobes are high, the push alone takes effect.
  - With neither strobe high, `stk_addr` equals the stack pointer.
- R4: Register map and reads:
  - The bus decodes four addresses: status at 0x10, stack pointer at 0x11, data-pointer low byte at 0x12 and data-pointer high byte at 0x13.
  - `sfr_rdata` shows the addressed register in the same cycle.
  - Any other address reads 0x00, and a write to it changes nothing.
- R5: Parity:
  - Status bit 0 always reads as the XOR of the eight `acc` bits, which makes the count of ones in the nine bits even.
  - A software write to bit 0 has no effect.
- R6: Status layout and bank output:
  - The status bits are: bit 7 carry, bit 6 auxiliary carry, bit 5 user flag A, bits 4:3 bank select, bit 2 overflow, bit 1 user flag B, bit 0 parity.
  - `bank_base` equals bank select times 8, giving 0x00, 0x08, 0x10 or 0x18.
  - The two user flags and the bank select are plain read/write bits.
- R7: ALU updates:
  - `cy_we`, `ac_we` and `ov_we` load `cy_in`, `ac_in` and `ov_in` into their bits at the next edge.
  - Each strobe beats a software status write in the same cycle, but only for its own bit.
- R8: Data pointer writes:
  - A byte write changes only the addressed half.
  - `dptr_ld` loads all 16 bits from `dptr_ld_data` in one cycle.
  - `dptr_ld` beats a byte write in the same cycle.
  - `dptr` always shows the stored value.
- R9: Stack pointer writes:
  - A software write to 0x11 sets the stack pointer at the next edge.
  - A push or pop in the same cycle takes effect in place of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Special-register address |
| sfr_wr | input | 1 | Write strobe for the addressed register |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Combinational read data |
| push | input | 1 | Push/call strobe |
| pop | input | 1 | Pop/return strobe |
| cy_we | input | 1 | Carry update strobe |
| cy_in | input | 1 | New carry value |
| ac_we | input | 1 | Auxiliary carry update strobe |
| ac_in | input | 1 | New auxiliary carry value |
| ov_we | input | 1 | Overflow update strobe |
| ov_in | input | 1 | New overflow value |
| acc | input | 8 | Current accumulator value |
| dptr_ld | input | 1 | 16-bit data pointer load strobe |
| dptr_ld_data | input | 16 | 16-bit load value |
| stk_addr | output | 8 | Stack address for this cycle's access |
| bank_base | output | 8 | Base address of the selected register bank |
| dptr | output | 16 | Full data pointer |

## Verification
Some outputs depend only on inputs and current state. These are `sfr_rdata`, `stk_addr` and the parity bit, and they are due in the same cycle as the stimulus. The bench samples them one nanosecond after inputs change at the falling edge. Every register update becomes visible one edge later, through `dptr`, `bank_base` and read-back. The bench model therefore commits each cycle's inputs at the rising edge and compares on the next falling-edge sample. Random cycles mix strobe collisions, and directed cycles cover wrap-around, the first push and the ignored parity write.

// File: rtl/mcu_sreg_unit.sv
module mcu_sreg_unit #(
  parameter logic [7:0] ADDR_STAT = 8'h10,
  parameter logic [7:0] ADDR_SP   = 8'h11,
  parameter logic [7:0] ADDR_DLO  = 8'h12,
  parameter logic [7:0] ADDR_DHI  = 8'h13,
  parameter logic [7:0] SP_INIT   = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        push,
  input  logic        pop,
  input  logic        cy_we,
  input  logic        cy_in,
  input  logic        ac_we,
  input  logic        ac_in,
  input  logic        ov_we,
  input  logic        ov_in,
  input  logic [7:0]  acc,
  input  logic        dptr_ld,
  input  logic [15:0] dptr_ld_data,
  output logic [7:0]  stk_addr,
  output logic [7:0]  bank_base,
  output logic [15:0] dptr
);

  logic [7:0]  sp;
  logic [15:0] dp;
  logic        cy, ac, fa, ov, fb;
  logic [1:0]  bank;

  wire wr_stat = sfr_wr && sfr_addr == ADDR_STAT;
  wire wr_sp   = sfr_wr && sfr_addr == ADDR_SP;
  wire wr_dlo  = sfr_wr && sfr_addr == ADDR_DLO;
  wire wr_dhi  = sfr_wr && sfr_addr == ADDR_DHI;
  wire [7:0] sp_inc = sp + 8'd1;
  wire [7:0] status = {cy, ac, fa, bank, ov, fb, ^acc};

  assign stk_addr  = push ? sp_inc : sp;
  assign bank_base = {3'b000, bank, 3'b000};
  assign dptr      = dp;

  always_comb begin
    case (sfr_addr)
      ADDR_STAT: sfr_rdata = status;
      ADDR_SP:   sfr_rdata = sp;
      ADDR_DLO:  sfr_rdata = dp[7:0];
      ADDR_DHI:  sfr_rdata = dp[15:8];
      default:   sfr_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= SP_INIT;
    end else if (push) begin
      sp <= sp_inc;
    end else if (pop) begin
      sp <= sp - 8'd1;
    end else if (wr_sp) begin
      sp <= sfr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp <= '0;
    end else if (dptr_ld) begin
      dp <= dptr_ld_data;
    end else begin
      if (wr_dlo) dp[7:0]  <= sfr_wdata;
      if (wr_dhi) dp[15:8] <= sfr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cy, ac, fa, bank, ov, fb} <= '0;
    end else begin
      if (wr_stat) begin
        fa   <= sfr_wdata[5];
        bank <= sfr_wdata[4:3];
        fb   <= sfr_wdata[1];
      end
      if (cy_we)        cy <= cy_in;
      else if (wr_stat) cy <= sfr_wdata[7];
      if (ac_we)        ac <= ac_in;
      else if (wr_stat) ac <= sfr_wdata[6];
      if (ov_we)        ov <= ov_in;
      else if (wr_stat) ov <= sfr_wdata[2];
    end
  end

  assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp == $past(stk_addr));
  assert_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp == $past(stk_addr) - 8'd1);
  assert_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat) |=> bank_base == {3'b000, $past(sfr_wdata[4:3]), 3'b000});
  assert_alu_cy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cy_we |=> cy == $past(cy_in));
  assert_alu_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_we |=> ov == $past(ov_in));
  assert_dptr_ld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dptr_ld |=> dptr == $past(dptr_ld_data));
  assert_sp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !wr_sp) |=> $stable(sp));

endmodule

// File: tb/sim_mcu_sreg_unit.sv
`timescale 1ns/1ps
module sim_mcu_sreg_unit;
  logic clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, acc = 0;
  logic sfr_wr = 0, push = 0, pop = 0;
  logic cy_we = 0, cy_in = 0, ac_we = 0, ac_in = 0, ov_we = 0, ov_in = 0;
  logic dptr_ld = 0;
  logic [15:0] dptr_ld_data = 0;
  logic [7:0] sfr_rdata, stk_addr, bank_base;
  logic [15:0] dptr;

  int checks = 0, errors = 0;
  logic [7:0] m_sp = 8'h07;
  logic [15:0] m_dp = 0;
  logic [6:0] m_st = 0;

  always #2.5 clk = ~clk;

  mcu_sreg_unit u0 (.*);

  function automatic logic [7:0] exp_stat();
    return {m_st[6:2], m_st[1], m_st[0], ^acc} ;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h10: return {m_st[6], m_st[5], m_st[4], m_st[3:2], m_st[1], m_st[0], ^acc};
      8'h11: return m_sp;
      8'h12: return m_dp[7:0];
      8'h13: return m_dp[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic commit();
    if (sfr_wr && sfr_addr == 8'h10) begin
      m_st[4] = sfr_wdata[5]; m_st[3:2] = sfr_wdata[4:3]; m_st[0] = sfr_wdata[1];
      m_st[6] = sfr_wdata[7]; m_st[5] = sfr_wdata[6]; m_st[1] = sfr_wdata[2];
    end
    if (cy_we) m_st[6] = cy_in;
    if (ac_we) m_st[5] = ac_in;
    if (ov_we) m_st[1] = ov_in;
    if (push) m_sp = m_sp + 8'd1;
    else if (pop) m_sp = m_sp - 8'd1;
    else if (sfr_wr && sfr_addr == 8'h11) m_sp = sfr_wdata;
    if (dptr_ld) m_dp = dptr_ld_data;
    else begin
      if (sfr_wr && sfr_addr == 8'h12) m_dp[7:0] = sfr_wdata;
      if (sfr_wr && sfr_addr == 8'h13) m_dp[15:8] = sfr_wdata;
    end
  endtask

  task automatic idle();
    sfr_wr = 0; push = 0; pop = 0; cy_we = 0; ac_we = 0; ov_we = 0; dptr_ld = 0;
  endtask

  task automatic cycle();
    #1;
    chk("R4 read", {8'h00, sfr_rdata}, {8'h00, exp_rd(sfr_addr)});
    chk(push ? "R2 stk_addr" : "R3 stk_addr", {8'h00, stk_addr}, {8'h00, push ? m_sp + 8'd1 : m_sp});
    chk("R6 bank_base", {8'h00, bank_base}, {8'h00, 3'b000, m_st[3:2], 3'b000});
    chk("R8 dptr", dptr, m_dp);
    @(posedge clk);
    commit();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    #3;
    acc = 8'h00;
    sfr_addr = 8'h11; #1; chk("R1 sp reset", {8'h00, sfr_rdata}, 16'h0007);
    chk("R1 dptr reset", dptr, 16'h0000);
    chk("R1 bank reset", {8'h00, bank_base}, 16'h0000);
    sfr_addr = 8'h10; #1; chk("R1 status reset", {8'h00, sfr_rdata}, 16'h0000);
    @(negedge clk); rst_n = 1; @(negedge clk);
    push = 1; #1; chk("R2 first push", {8'h00, stk_addr}, 16'h0008); cycle();
    sfr_addr = 8'h10; acc = 8'h07; sfr_wr = 1; sfr_wdata = 8'h00; cycle();
    sfr_addr = 8'h10; acc = 8'h07; #1; chk("R5 parity live", {15'h0, sfr_rdata[0]}, 16'h0001);
    sfr_wr = 1; sfr_wdata = 8'h01; acc = 8'h03; cycle();
    sfr_addr = 8'h10; #1; chk("R5 write ignored", {15'h0, sfr_rdata[0]}, 16'h0000);
    sfr_addr = 8'h11; sfr_wr = 1; sfr_wdata = 8'h00; cycle();
    pop = 1; sfr_addr = 8'h11; cycle();
    #1; chk("R3 pop wrap", {8'h00, sfr_rdata}, 16'h00FF);
    push = 1; pop = 1; cycle();
    #1; chk("R3 push beats pop", {8'h00, sfr_rdata}, 16'h0000);
    sfr_addr = 8'h11; sfr_wr = 1; sfr_wdata = 8'h40; pop = 1; cycle();
    #1; chk("R9 strobe beats write", {8'h00, sfr_rdata}, 16'h00FF);
    sfr_addr = 8'h10; sfr_wr = 1; sfr_wdata = 8'hFF; cy_we = 1; cy_in = 0; cycle();
    #1; chk("R7 alu wins", {8'h00, sfr_rdata[7:1], 1'b0}, 16'h007E);
    sfr_addr = 8'h12; sfr_wr = 1; sfr_wdata = 8'hAA; dptr_ld = 1; dptr_ld_data = 16'h1234; cycle();
    #1; chk("R8 ld beats byte", dptr, 16'h1234);
    sfr_addr = 8'h13; sfr_wr = 1; sfr_wdata = 8'h9C; cycle();
    #1; chk("R8 high byte only", dptr, 16'h9C34);
    sfr_addr = 8'h20; sfr_wr = 1; sfr_wdata = 8'h55; cycle();
    #1; chk("R4 unmapped", {8'h00, sfr_rdata}, 16'h0000);
    for (int i = 0; i < 3000; i++) begin
      sfr_addr = 8'h10 + 8'($urandom_range(0, 4));
      sfr_wr = ($urandom_range(0, 2) == 0);
      sfr_wdata = 8'($urandom);
      push = ($urandom_range(0, 3) == 0);
      pop = ($urandom_range(0, 3) == 0);
      cy_we = ($urandom_range(0, 3) == 0); cy_in = 1'($urandom);
      ac_we = ($urandom_range(0, 3) == 0); ac_in = 1'($urandom);
      ov_we = ($urandom_range(0, 3) == 0); ov_in = 1'($urandom);
      acc = 8'($urandom);
      dptr_ld = ($urandom_range(0, 5) == 0); dptr_ld_data = 16'($urandom);
      cycle();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule